// File: doc/BRIEF.md
# NAND Flash Identification Sequencer

This block is a host-side engine for an asynchronous 8-bit NAND flash bus. One start pulse makes it select the device and write the reset opcode. It then waits for the ready/busy line to show the device is free, writes the read-identifier opcode and a single zero address, and reads a chosen number of identifier bytes into a small internal byte file. When the last byte is stored, it raises a one-cycle completion pulse. The first stored byte is the manufacturer code.

Every bus phase is timed in system clock cycles set by parameters. The ready/busy input passes through a two-flop synchronizer before use. A timeout counter ends the wait if the device never becomes ready. The data bus is split into an outgoing byte, an incoming byte and an output enable, so a pad ring can build the bidirectional pins. The captured bytes are held on a parallel output until the next start. No stream interface is involved, so there are no back-pressure rules.

Top module: `nand_id_seq`

## Requirements
- R1: Out of reset the bus is idle: ce_n=1, we_n=1, re_n=1, cle=0, ale=0, dq_oe=0, and done, error and busy are all 0.
- R2: After start, ce_n falls before the first write strobe. The first byte written is the reset opcode 0xFF, with cle=1 and ale=0. Each written byte is taken by the device on the rising edge of we_n, and ce_n is low on every we_n or re_n low cycle.
- R3: Each write strobe holds we_n low for WE_LO cycles and high for WE_HI cycles, both 2 by default. cle, ale, dq_out and dq_oe=1 are held steady through the rising edge.
- R4: No read-identifier opcode is written until the synchronized ready/busy line has returned high after the reset opcode.
- R5: The read-identifier opcode 0x90 is written with cle=1. It is followed by exactly one address write of 0x00 with ale=1 and cle=0. cle and ale are never high together.
- R6: dq_oe is low for at least one cycle before the first fall of re_n, and is low on every cycle that re_n is low.
- R7: Identifier bytes are taken one per re_n pulse, at the cycle in which re_n rises. re_n is low for RE_LO cycles and, between back-to-back pulses, high for RE_HI cycles. Byte k is stored in id_bytes[8k+7:8k], with byte 0 being the manufacturer code. Bytes beyond the requested count read as 0x00.
- R8: The id_count input is sampled at start. A value of 0 is treated as 1, and values above ID_MAX (8) are treated as ID_MAX.
- R9: done is high for exactly one cycle, in the cycle after the last byte is stored. The run then ends with ce_n high and busy low.
- R10: If ready/busy stays low for TIMEOUT cycles, error goes high, ce_n goes high, no read-identifier opcode is written and done is not raised. error clears at the next start.
- R11: A start pulse while busy is high is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | begin a reset plus identifier read |
| id_count | input | 4 | number of identifier bytes to read (clamped 1..ID_MAX) |
| busy | output | 1 | a sequence is in progress |
| done | output | 1 | one-cycle pulse after the last byte is stored |
| error | output | 1 | ready/busy timeout occurred; held until next start |
| id_bytes | output | 64 | captured bytes, byte k at bits 8k+7:8k |
| ce_n | output | 1 | chip enable, active low |
| cle | output | 1 | command latch enable |
| ale | output | 1 | address latch enable |
| we_n | output | 1 | write strobe, active low |
| re_n | output | 1 | read strobe, active low |
| dq_out | output | 8 | byte driven toward the flash |
| dq_oe | output | 1 | host drives the data bus when high |
| dq_in | input | 8 | byte returned by the flash |
| rb_n | input | 1 | ready/busy from the flash, low while busy |

## Verification
The bound assertions check the bus-level rules on every cycle:
- chip enable is low under every strobe;
- cle and ale are exclusive;
- data and latch enables are steady at each write-strobe rise;
- the output enable is low before and during read strobes;
- done lasts one cycle, and an error leaves the chip deselected.

The order of operations can only be shown by the bench's scenarios, against a behavioural flash model: reset first, then the wait for ready, then the opcode and single address. The same holds for the exact strobe widths, the captured byte contents for different counts, the count clamping, the timeout path with recovery, and the ignored restart.

// File: rtl/nid_pkg.sv
package nid_pkg;
  localparam logic [7:0] OP_RESET  = 8'hFF;
  localparam logic [7:0] OP_READID = 8'h90;
  localparam logic [7:0] ADDR_ID   = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE, S_CE, S_RST_GO, S_RST, S_GUARD, S_WAIT,
    S_ID_GO, S_ID, S_AD_GO, S_AD, S_TURN, S_RD_GO, S_RD, S_TAIL
  } nid_state_e;
endpackage

// File: rtl/nid_sync.sv
module nid_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nid_pulse.sv
// Timed active-low strobe: LO cycles low, then HI cycles high.
// A new go is accepted while idle or in the final high cycle.
module nid_pulse #(
  parameter int LO = 2,
  parameter int HI = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic strobe_n,
  output logic cap,
  output logic fin
);
  localparam int MAXC = (LO > HI) ? LO : HI;
  localparam int CW   = $clog2(MAXC + 1);

  logic          active;
  logic          low_ph;
  logic [CW-1:0] cnt;

  assign cap = active &&  low_ph && (cnt == CW'(LO - 1));
  assign fin = active && !low_ph && (cnt == CW'(HI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      low_ph   <= 1'b0;
      cnt      <= '0;
      strobe_n <= 1'b1;
    end else if (go && (!active || fin)) begin
      active   <= 1'b1;
      low_ph   <= 1'b1;
      cnt      <= '0;
      strobe_n <= 1'b0;
    end else if (cap) begin
      low_ph   <= 1'b0;
      cnt      <= '0;
      strobe_n <= 1'b1;
    end else if (fin) begin
      active   <= 1'b0;
    end else if (active) begin
      cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nand_id_seq.sv
module nand_id_seq
  import nid_pkg::*;
#(
  parameter int ID_MAX  = 8,
  parameter int WE_LO   = 2,
  parameter int WE_HI   = 2,
  parameter int RE_LO   = 2,
  parameter int RE_HI   = 2,
  parameter int GUARD   = 4,
  parameter int TIMEOUT = 5000,
  localparam int CW = $clog2(ID_MAX + 1),
  localparam int IW = $clog2(ID_MAX),
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CW-1:0]      id_count,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic [ID_MAX*8-1:0] id_bytes,
  output logic               ce_n,
  output logic               cle,
  output logic               ale,
  output logic               we_n,
  output logic               re_n,
  output logic [7:0]         dq_out,
  output logic               dq_oe,
  input  logic [7:0]         dq_in,
  input  logic               rb_n
);
  nid_state_e    state;
  logic [TW-1:0] tcnt;
  logic [IW-1:0] idx;
  logic [CW-1:0] nlat;
  logic [CW-1:0] n_req;
  logic          rb_s;
  logic          go_we, go_re;
  logic          we_cap, we_fin, re_cap, re_fin;
  logic          clr_file;
  logic          last_byte;

  nid_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .d(rb_n), .q(rb_s)
  );

  nid_pulse #(.LO(WE_LO), .HI(WE_HI)) u_we (
    .clk(clk), .rst_n(rst_n), .go(go_we),
    .strobe_n(we_n), .cap(we_cap), .fin(we_fin)
  );

  nid_pulse #(.LO(RE_LO), .HI(RE_HI)) u_re (
    .clk(clk), .rst_n(rst_n), .go(go_re),
    .strobe_n(re_n), .cap(re_cap), .fin(re_fin)
  );

  always_comb begin
    if (id_count == '0)                 n_req = CW'(1);
    else if (id_count > CW'(ID_MAX))    n_req = CW'(ID_MAX);
    else                                n_req = id_count;
  end

  assign go_we     = (state == S_RST_GO) || (state == S_ID_GO) || (state == S_AD_GO);
  assign go_re     = (state == S_RD_GO) || ((state == S_RD) && re_fin);
  assign clr_file  = (state == S_IDLE) && start;
  assign last_byte = (idx == IW'(nlat - CW'(1)));
  assign busy      = (state != S_IDLE);

  // Byte file, one register per identifier byte
  for (genvar g = 0; g < ID_MAX; g++) begin : g_file
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   id_bytes[g*8 +: 8] <= 8'h00;
      else if (clr_file)                            id_bytes[g*8 +: 8] <= 8'h00;
      else if (state == S_RD && re_cap && idx == IW'(g)) id_bytes[g*8 +: 8] <= dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ce_n   <= 1'b1;
      cle    <= 1'b0;
      ale    <= 1'b0;
      dq_out <= 8'h00;
      dq_oe  <= 1'b0;
      tcnt   <= '0;
      idx    <= '0;
      nlat   <= CW'(1);
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          ce_n  <= 1'b0;
          error <= 1'b0;
          nlat  <= n_req;
          state <= S_CE;
        end
        S_CE: begin
          cle    <= 1'b1;
          dq_out <= OP_RESET;
          dq_oe  <= 1'b1;
          state  <= S_RST_GO;
        end
        S_RST_GO: state <= S_RST;
        S_RST: if (we_fin) begin
          cle   <= 1'b0;
          dq_oe <= 1'b0;
          tcnt  <= '0;
          state <= S_GUARD;
        end
        S_GUARD: begin
          if (tcnt == TW'(GUARD - 1)) begin
            tcnt  <= '0;
            state <= S_WAIT;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (rb_s) begin
            cle    <= 1'b1;
            dq_out <= OP_READID;
            dq_oe  <= 1'b1;
            state  <= S_ID_GO;
          end else if (tcnt == TW'(TIMEOUT - 1)) begin
            error <= 1'b1;
            ce_n  <= 1'b1;
            state <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_ID_GO: state <= S_ID;
        S_ID: if (we_fin) begin
          cle    <= 1'b0;
          ale    <= 1'b1;
          dq_out <= ADDR_ID;
          state  <= S_AD_GO;
        end
        S_AD_GO: state <= S_AD;
        S_AD: if (we_fin) begin
          ale   <= 1'b0;
          dq_oe <= 1'b0;
          idx   <= '0;
          state <= S_TURN;
        end
        S_TURN:  state <= S_RD_GO;
        S_RD_GO: state <= S_RD;
        S_RD: begin
          if (re_cap && last_byte) begin
            done  <= 1'b1;
            state <= S_TAIL;
          end else if (re_fin) begin
            idx <= idx + 1'b1;
          end
        end
        S_TAIL: if (re_fin) begin
          ce_n  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nid_seq_chk.sv
module nid_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic       ce_n,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       re_n,
  input logic [7:0] dq_out,
  input logic       dq_oe
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ce_n && we_n && re_n && !cle && !ale));

  a_r2_ce_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);

  a_r3_latch_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(dq_out) && $stable(cle) && $stable(ale) && dq_oe && (cle || ale)));

  a_r5_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  a_r6_oe_off_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);

  a_r6_oe_off_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(re_n) |-> $past(!dq_oe));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_error_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> (ce_n && !done));
endmodule

bind nand_id_seq nid_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
  .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/nand_id_seq_tb.sv
module nand_id_seq_tb;
  localparam int WE_LO = 2, RE_LO = 2, RE_HI = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  id_count = 4'd4;
  logic        busy, done, error, ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [63:0] id_bytes;
  logic [7:0]  dq_out, dq_in;
  logic        rb_n = 1'b1;

  int total = 0, bad = 0;
  int cyc = 0;

  nand_id_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .id_count(id_count),
    .busy(busy), .done(done), .error(error), .id_bytes(id_bytes),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rb_n(rb_n)
  );

  always #10 clk = ~clk;

  // ---------------- flash model ----------------
  logic [7:0] rom [8];
  initial begin
    rom[0] = 8'h45; rom[1] = 8'h48; rom[2] = 8'h9A; rom[3] = 8'hB3;
    rom[4] = 8'h7E; rom[5] = 8'h72; rom[6] = 8'h0D; rom[7] = 8'h0E;
  end

  int  rd_ptr = 0;
  bit  reset_seen = 0;
  bit  rb_stuck = 0;
  int  busy_len = 20;
  int  rb_rise_cyc = 0;
  event rst_ev;

  logic [7:0] log_dat [16];
  logic       log_cle [16];
  logic       log_ale [16];
  logic       log_ce  [16];
  logic       log_oe  [16];
  int         log_cyc [16];
  int         log_n = 0;

  assign dq_in = reset_seen ? rom[rd_ptr % 8] : 8'h5A;

  always @(posedge we_n) begin
    if (log_n < 16) begin
      log_dat[log_n] = dq_out; log_cle[log_n] = cle; log_ale[log_n] = ale;
      log_ce[log_n] = ce_n; log_oe[log_n] = dq_oe; log_cyc[log_n] = cyc;
      log_n++;
    end
    if (cle && dq_out == 8'hFF) begin reset_seen = 1; -> rst_ev; end
    if (cle && dq_out == 8'h90) rd_ptr = 0;
  end

  always @(posedge re_n) if (rst_n) rd_ptr++;

  initial forever begin
    @(rst_ev);
    repeat (2) @(posedge clk);
    rb_n = 1'b0;
    if (rb_stuck) wait (!rb_stuck);
    else repeat (busy_len) @(posedge clk);
    rb_n = 1'b1;
    rb_rise_cyc = cyc;
  end

  // ---------------- monitor ----------------
  int we_run = 0, re_run = 0, re_gap = 0;
  bit re_prev_pulse = 0;
  int we_len_err = 0, re_len_err = 0, re_gap_err = 0, oe_err = 0;
  int done_cnt = 0;
  logic prev_we = 1, prev_re = 1, prev_oe = 0;

  always @(negedge clk) begin
    cyc++;
    if (!we_n) we_run++;
    else if (!prev_we) begin if (we_run != WE_LO) we_len_err++; we_run = 0; end
    if (!re_n) begin
      if (prev_re) begin
        if (prev_oe) oe_err++;
        if (re_prev_pulse && re_gap != RE_HI) re_gap_err++;
      end
      re_run++;
    end else begin
      if (!prev_re) begin
        if (re_run != RE_LO) re_len_err++;
        re_run = 0; re_gap = 0; re_prev_pulse = 1;
      end
      re_gap++;
    end
    if (!re_n && dq_oe) oe_err++;
    if (ce_n) re_prev_pulse = 0;
    if (done) done_cnt++;
    prev_we = we_n; prev_re = re_n; prev_oe = dq_oe;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    log_n = 0; reset_seen = 0; rd_ptr = 0;
    we_len_err = 0; re_len_err = 0; re_gap_err = 0; oe_err = 0; done_cnt = 0;
  endtask

  task automatic kick(input logic [3:0] n);
    @(negedge clk); id_count = n; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(output bit saw_done, output bit saw_err);
    saw_done = 0; saw_err = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done)  begin saw_done = 1; break; end
      if (error) begin saw_err = 1; break; end
    end
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [63:0] expect_bytes(input int n);
    logic [63:0] v = '0;
    for (int k = 0; k < n; k++) v[k*8 +: 8] = rom[k];
    return v;
  endfunction

  task automatic run_good(input logic [3:0] req, input int eff, input string tag);
    bit d, e;
    clear_model();
    kick(req);
    wait_end(d, e);
    check(d && !e, {tag, " R9 done seen"}, {d, e}, 2'b10);
    check(done_cnt == 1, {tag, " R9 done one cycle"}, done_cnt, 1);
    check(ce_n && !busy, {tag, " R9 idle after"}, {ce_n, busy}, 2'b10);
    check(id_bytes == expect_bytes(eff), {tag, " R7 bytes"}, id_bytes, expect_bytes(eff));
    check(re_len_err == 0 && re_gap_err == 0, {tag, " R7 re timing"}, re_len_err + re_gap_err, 0);
    check(oe_err == 0, {tag, " R6 oe"}, oe_err, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    check(ce_n && we_n && re_n && !cle && !ale && !dq_oe, "R1 bus idle",
          {ce_n, we_n, re_n, cle, ale, dq_oe}, 6'b111000);
    check(!done && !error && !busy, "R1 status", {done, error, busy}, 3'b000);
  endtask

  task automatic t_basic();
    run_good(4'd4, 4, "basic");
    check(log_n == 3, "R5 three writes", log_n, 3);
    check(log_dat[0] == 8'hFF && log_cle[0] && !log_ale[0] && !log_ce[0] && log_oe[0],
          "R2 reset opcode", log_dat[0], 8'hFF);
    check(log_dat[1] == 8'h90 && log_cle[1] && !log_ale[1] && !log_ce[1],
          "R5 readid opcode", log_dat[1], 8'h90);
    check(log_dat[2] == 8'h00 && log_ale[2] && !log_cle[2] && !log_ce[2],
          "R5 address", {log_ale[2], log_dat[2]}, 9'h100);
    check(log_cyc[1] > rb_rise_cyc, "R4 wait ready", log_cyc[1], rb_rise_cyc);
    check(we_len_err == 0, "R3 we low width", we_len_err, 0);
    check(id_bytes[7:0] == 8'h45, "R7 manufacturer byte", id_bytes[7:0], 8'h45);
  endtask

  task automatic t_long_busy();
    busy_len = 300;
    run_good(4'd8, 8, "long busy");
    check(log_cyc[1] > rb_rise_cyc, "R4 wait long ready", log_cyc[1], rb_rise_cyc);
    busy_len = 20;
  endtask

  task automatic t_count_zero();
    run_good(4'd0, 1, "count0 R8");
  endtask

  task automatic t_count_big();
    run_good(4'd13, 8, "count13 R8");
  endtask

  task automatic t_count_one();
    run_good(4'd1, 1, "count1 R7");
  endtask

  task automatic t_timeout();
    bit d, e;
    clear_model();
    rb_stuck = 1;
    kick(4'd4);
    wait_end(d, e);
    check(e && !d, "R10 error raised", {e, d}, 2'b10);
    check(error && ce_n && !busy, "R10 deselected", {error, ce_n, busy}, 3'b110);
    check(log_n == 1, "R10 no readid", log_n, 1);
    check(done_cnt == 0, "R10 no done", done_cnt, 0);
    rb_stuck = 0;
    repeat (5) @(negedge clk);
    clear_model();
    kick(4'd2);
    check(!error, "R10 error cleared at start", error, 0);
    wait_end(d, e);
    check(d && id_bytes == expect_bytes(2), "R10 recovery run", id_bytes, expect_bytes(2));
  endtask

  task automatic t_start_ignored();
    bit d, e;
    clear_model();
    kick(4'd3);
    repeat (10) @(negedge clk);
    id_count = 4'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_end(d, e);
    check(log_n == 3, "R11 single sequence", log_n, 3);
    check(id_bytes == expect_bytes(3), "R11 original count", id_bytes, expect_bytes(3));
    check(done_cnt == 1, "R11 one done", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_basic();
    t_long_busy();
    t_count_zero();
    t_count_big();
    t_count_one();
    t_timeout();
    t_start_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule